// File: doc/BRIEF.md
# FIFO-to-Memory Write Engine

This block empties a local word FIFO into a contiguous region of memory. Software programs a destination byte address and a byte count through a small register port, then sets a start bit. The engine pops one 32-bit word at a time from a show-ahead FIFO. It writes each word to memory as a single-word transfer on a memory-mapped master port and steps the address by four bytes after every accepted write. When the byte count has been used up, it raises a completion flag that software polls.

The core is a four-state controller. IDLE waits for a start request. A start with a non-zero word count moves to FETCH, and a start with a zero count goes straight to FINISH. FETCH pops a word as soon as the FIFO reports data and moves to WRITE. WRITE drives the master write until the slave stops asserting waitrequest. It then returns to FETCH, or goes to FINISH when the accepted word was the last one. FINISH sets the completion flag and always returns to IDLE.

An empty FIFO only makes the engine wait in FETCH. It does not raise an error. The two lowest bits of the address and count registers are dropped, so every transfer is word aligned and a whole number of words long.

Top module: `fifo_mem_writer`

## Requirements
- R1: After reset the master write and FIFO pop are low, and the status register reads zero.
- R2: Register word offsets are status 0, control 1, destination address 2 and byte count 3. The address and count registers read back what was written, with bits 1:0 forced to zero.
- R3: Writing 1 to control bit 0 while idle starts a transfer. Control reads as zero. Status bit 1 (busy) reads 1 from the start until completion.
- R4: Every transfer is a single-word write with byteenable 4'hF. Write k (from 0) goes to the programmed address plus 4k and carries the k-th word popped from the FIFO during this transfer.
- R5: While waitrequest is high, the master keeps write asserted and holds the address and write data unchanged.
- R6: A FIFO pop happens only when the FIFO is non-empty and no master write is outstanding.
- R7: After exactly count/4 accepted writes, status bit 0 (done) reads 1 and busy reads 0.
- R8: A start request made while busy is ignored, including one in the cycle in which the final write is accepted. The ongoing transfer keeps its address and count, even if those registers are rewritten.
- R9: Starting a transfer clears done.
- R10: A byte count below 4 sets done without any pop or write.
- R11: While the FIFO stays empty and no word is held, no master write is issued and the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | 2 | Register word offset |
| s_write | input | 1 | Register write strobe |
| s_writedata | input | 32 | Register write data |
| s_read | input | 1 | Register read strobe |
| s_readdata | output | 32 | Register read data, same cycle as s_read |
| m_address | output | AW | Master byte address |
| m_write | output | 1 | Master write request |
| m_writedata | output | 32 | Master write data |
| m_byteenable | output | 4 | Master byte enables |
| m_waitrequest | input | 1 | Slave stall |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rdata | input | 32 | FIFO head word (show-ahead) |
| fifo_rd | output | 1 | FIFO pop |

## Verification
Two events can land in the same cycle: a start request on the control register, and acceptance of the final write of a running transfer. The bench keeps waitrequest low and the FIFO supplied, so it knows which acceptance is the last one. In exactly that cycle it writes the start bit, with extra bait words waiting in the FIFO. The check passes only if the write count stays at the programmed number, no further write appears, and status then shows done set and busy clear.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;
    localparam int REG_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_FINISH
    } fmw_state_t;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_CTRL   = 2'd1;
    localparam logic [1:0] RA_BASE   = 2'd2;
    localparam logic [1:0] RA_LEN    = 2'd3;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_BUSY_BIT = 1;
    localparam int CTRL_GO_BIT   = 0;

endpackage

// File: rtl/fmw_regs.sv
module fmw_regs
    import fmw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       s_addr,
    input  logic             s_write,
    input  logic [REG_W-1:0] s_writedata,
    input  logic             s_read,
    output logic [REG_W-1:0] s_readdata,
    input  logic             busy,
    input  logic             finish,
    output logic             go,
    output logic [AW-1:2]    base_q,
    output logic [LW-1:2]    len_q,
    output logic             done_q
);

    logic unused_wd;
    assign unused_wd = s_writedata[1];

    // start only honoured from idle
    assign go = s_write && (s_addr == RA_CTRL) && s_writedata[CTRL_GO_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (s_write && (s_addr == RA_BASE)) begin
                base_q <= s_writedata[AW-1:2];
            end
            if (s_write && (s_addr == RA_LEN)) begin
                len_q <= s_writedata[LW-1:2];
            end
            if (go) begin
                done_q <= 1'b0;
            end else if (finish) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        s_readdata = '0;
        if (s_read) begin
            unique case (s_addr)
                RA_STATUS: begin
                    s_readdata[STAT_DONE_BIT] = done_q;
                    s_readdata[STAT_BUSY_BIT] = busy;
                end
                RA_CTRL:   s_readdata = '0;
                RA_BASE:   s_readdata[AW-1:2] = base_q;
                RA_LEN:    s_readdata[LW-1:2] = len_q;
            endcase
        end
    end

endmodule

// File: rtl/fmw_addr_ctr.sv
module fmw_addr_ctr #(
    parameter int AW = 32,
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:2] base_in,
    input  logic [LW-1:2] len_in,
    output logic [AW-1:2] addr_q,
    output logic          last,
    output logic          len_zero
);

    localparam int AWW = AW - 2;
    localparam int LWW = LW - 2;
    localparam logic [AW-1:2] ADDR_STEP = AWW'(1);
    localparam logic [LW-1:2] WORD_ONE  = LWW'(1);

    logic [LW-1:2] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= base_in;
            rem_q  <= len_in;
        end else if (step) begin
            addr_q <= addr_q + ADDR_STEP;
            rem_q  <= rem_q - WORD_ONE;
        end
    end

    assign last     = (rem_q == WORD_ONE);
    assign len_zero = (len_in == '0);

endmodule

// File: rtl/fmw_fsm.sv
module fmw_fsm
    import fmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              len_zero,
    input  logic              last,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              m_waitrequest,
    output logic              fifo_rd,
    output logic              m_write,
    output logic [WORD_W-1:0] wdata_q,
    output logic              load,
    output logic              step,
    output logic              finish,
    output logic              busy
);

    fmw_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (fifo_rd) begin
                wdata_q <= fifo_rdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = len_zero ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (!fifo_empty) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (!m_waitrequest) begin
                    state_d = last ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fifo_rd = 1'b0;
        m_write = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        load    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = go;
            end
            ST_FETCH:  fifo_rd = !fifo_empty;
            ST_WRITE: begin
                m_write = 1'b1;
                step    = !m_waitrequest;
            end
            ST_FINISH: finish = 1'b1;
        endcase
    end

endmodule

// File: rtl/fifo_mem_writer.sv
module fifo_mem_writer
    import fmw_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        s_addr,
    input  logic              s_write,
    input  logic [REG_W-1:0]  s_writedata,
    input  logic              s_read,
    output logic [REG_W-1:0]  s_readdata,
    output logic [AW-1:0]     m_address,
    output logic              m_write,
    output logic [WORD_W-1:0] m_writedata,
    output logic [BE_W-1:0]   m_byteenable,
    input  logic              m_waitrequest,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd
);

    logic          go, busy, finish, done_q;
    logic          load, step, last, len_zero;
    logic [AW-1:2] base_q, addr_q;
    logic [LW-1:2] len_q;

    fmw_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_addr      (s_addr),
        .s_write     (s_write),
        .s_writedata (s_writedata),
        .s_read      (s_read),
        .s_readdata  (s_readdata),
        .busy        (busy),
        .finish      (finish),
        .go          (go),
        .base_q      (base_q),
        .len_q       (len_q),
        .done_q      (done_q)
    );

    fmw_addr_ctr #(.AW(AW), .LW(LW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base_in  (base_q),
        .len_in   (len_q),
        .addr_q   (addr_q),
        .last     (last),
        .len_zero (len_zero)
    );

    fmw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .len_zero      (len_zero),
        .last          (last),
        .fifo_empty    (fifo_empty),
        .fifo_rdata    (fifo_rdata),
        .m_waitrequest (m_waitrequest),
        .fifo_rd       (fifo_rd),
        .m_write       (m_write),
        .wdata_q       (m_writedata),
        .load          (load),
        .step          (step),
        .finish        (finish),
        .busy          (busy)
    );

    assign m_address    = {addr_q, 2'b00};
    assign m_byteenable = '1;

endmodule

// File: rtl/fmw_checker.sv
module fmw_checker
    import fmw_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_write,
    input logic              m_waitrequest,
    input logic [AW-1:0]     m_address,
    input logic [WORD_W-1:0] m_writedata,
    input logic              fifo_rd,
    input logic              fifo_empty,
    input logic              done_q,
    input logic              busy,
    input logic              go
);

    assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(m_address) && $stable(m_writedata)));

    assert_pop_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_empty && !m_write));

    assert_single_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !m_waitrequest) |=> !m_write);

    assert_go_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !done_q);

    assert_done_means_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !busy);

    assert_no_write_while_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_write) |-> $past(fifo_rd));

endmodule

bind fifo_mem_writer fmw_checker #(.AW(AW)) i_fmw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_write       (m_write),
    .m_waitrequest (m_waitrequest),
    .m_address     (m_address),
    .m_writedata   (m_writedata),
    .fifo_rd       (fifo_rd),
    .fifo_empty    (fifo_empty),
    .done_q        (done_q),
    .busy          (busy),
    .go            (go)
);

// File: tb/test_fifo_mem_writer.sv
`timescale 1ns/1ps
module test_fifo_mem_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  s_addr = 2'd0;
    logic        s_write = 1'b0;
    logic [31:0] s_writedata = '0;
    logic        s_read = 1'b0;
    logic [31:0] s_readdata;
    logic [31:0] m_address;
    logic        m_write;
    logic [31:0] m_writedata;
    logic [3:0]  m_byteenable;
    logic        m_waitrequest = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_rd;

    always #2.5 clk = ~clk;

    fifo_mem_writer i_fifo_mem_writer (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_write(s_write),
        .s_writedata(s_writedata), .s_read(s_read), .s_readdata(s_readdata),
        .m_address(m_address), .m_write(m_write), .m_writedata(m_writedata),
        .m_byteenable(m_byteenable), .m_waitrequest(m_waitrequest),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] fq [0:1023];
    int fq_wr = 0, fq_rd = 0;
    bit rnd_on = 0, force_empty = 0;
    bit pop_pend = 0, acc_pend = 0, hold_prev = 0, last_now = 0;
    logic [31:0] acc_a, acc_d, hold_a, hold_d;
    logic [31:0] wa [0:127];
    logic [31:0] wd [0:127];
    int wn = 0, expect_n = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // FIFO model, memory monitor and protocol checks
    always @(negedge clk) begin
        if (pop_pend) fq_rd++;
        if (acc_pend) begin
            if (wn < 128) begin
                wa[wn] = acc_a;
                wd[wn] = acc_d;
            end
            wn++;
        end
        m_waitrequest = rnd_on && ($urandom_range(4) < 2);
        fifo_empty    = force_empty || (rnd_on && $urandom_range(3) == 0) || (fq_rd >= fq_wr);
        fifo_rdata    = fq[fq_rd % 1024];
        #1;
        if (!rst_n) begin
            pop_pend = 0; acc_pend = 0; hold_prev = 0; last_now = 0;
        end else begin
            pop_pend = fifo_rd;
            if (fifo_rd) check(!fifo_empty && !m_write, "R6", {30'd0, fifo_empty, m_write}, 32'd0);
            if (hold_prev) check(m_write && m_address == hold_a && m_writedata == hold_d,
                                 "R5", m_address, hold_a);
            hold_prev = m_write && m_waitrequest;
            hold_a = m_address;
            hold_d = m_writedata;
            acc_pend = m_write && !m_waitrequest;
            acc_a = m_address;
            acc_d = m_writedata;
            if (acc_pend) check(m_byteenable == 4'hF, "R4", {28'd0, m_byteenable}, 32'hF);
            last_now = acc_pend && (wn + 1 == expect_n);
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        s_write = 1'b1; s_addr = a; s_writedata = d;
        @(negedge clk);
        s_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        s_read = 1'b1; s_addr = a;
        #1.5;
        d = s_readdata;
        s_read = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] st;
        bit got = 0;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(2'd0, st);
            if (st[0]) begin got = 1; break; end
        end
        check(got, req, {31'd0, got}, 32'd1);
    endtask

    function automatic int push_words(input int n);
        int start = fq_wr;
        for (int i = 0; i < n; i++) begin
            fq[fq_wr % 1024] = $urandom;
            fq_wr++;
        end
        return start;
    endfunction

    task automatic verify_writes(input logic [31:0] base, input int n, input int start);
        check(wn == n, "R7", wn, n);
        for (int i = 0; i < n && i < 128; i++) begin
            check(wa[i] == ((base & 32'hFFFF_FFFC) + 4 * i), "R4", wa[i], (base & 32'hFFFF_FFFC) + 4 * i);
            check(wd[i] == fq[(start + i) % 1024], "R4", wd[i], fq[(start + i) % 1024]);
        end
    endtask

    task automatic run_xfer(input logic [31:0] base, input int n, input logic [1:0] lowbits);
        int start;
        logic [31:0] st;
        start = push_words(n);
        wn = 0; expect_n = n;
        reg_wr(2'd2, base);
        reg_wr(2'd3, n * 4 + lowbits);
        reg_wr(2'd1, 32'd1);
        wait_done("R7");
        verify_writes(base, n, start);
        reg_rd(2'd0, st);
        check(st == 32'd1, "R7", st, 32'd1);
    endtask

    initial begin
        logic [31:0] rd;
        int start;
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1.5;
        check(m_write == 1'b0 && fifo_rd == 1'b0, "R1", {30'd0, m_write, fifo_rd}, 32'd0);
        reg_rd(2'd0, rd);
        check(rd == 32'd0, "R1", rd, 32'd0);

        // R2 register map and low bits
        reg_wr(2'd2, 32'h0000_1003);
        reg_rd(2'd2, rd);
        check(rd == 32'h0000_1000, "R2", rd, 32'h0000_1000);
        reg_wr(2'd3, 32'h0000_0107);
        reg_rd(2'd3, rd);
        check(rd == 32'h0000_0104, "R2", rd, 32'h0000_0104);
        reg_rd(2'd1, rd);
        check(rd == 32'd0, "R2", rd, 32'd0);

        // R11 stall on empty, R3 busy and control read
        start = push_words(8);
        wn = 0; expect_n = 8;
        force_empty = 1;
        reg_wr(2'd2, 32'h0000_2002);
        reg_wr(2'd3, 32'd35);
        reg_wr(2'd1, 32'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1.5;
            check(m_write == 1'b0, "R11", {31'd0, m_write}, 32'd0);
        end
        check(wn == 0, "R11", wn, 0);
        reg_rd(2'd0, rd);
        check(rd == 32'd2, "R3", rd, 32'd2);
        reg_rd(2'd1, rd);
        check(rd == 32'd0, "R3", rd, 32'd0);
        force_empty = 0;
        wait_done("R7");
        verify_writes(32'h0000_2000, 8, start);
        reg_rd(2'd0, rd);
        check(rd == 32'd1, "R7", rd, 32'd1);

        // R9 done cleared by start; R8 start and base rewrite while busy
        rnd_on = 1;
        start = push_words(16);
        wn = 0; expect_n = 16;
        reg_wr(2'd2, 32'h0000_4000);
        reg_wr(2'd3, 32'd64);
        reg_wr(2'd1, 32'd1);
        reg_rd(2'd0, rd);
        check(rd[0] == 1'b0, "R9", rd, {rd[31:1], 1'b0});
        reg_wr(2'd2, 32'h0000_9000);
        reg_wr(2'd1, 32'd1);
        wait_done("R8");
        verify_writes(32'h0000_4000, 16, start);
        repeat (10) @(negedge clk);
        check(wn == 16, "R8", wn, 16);
        reg_rd(2'd2, rd);
        check(rd == 32'h0000_9000, "R2", rd, 32'h0000_9000);

        // R10 zero length (low bits only)
        wn = 0; expect_n = 0;
        start = fq_rd;
        reg_wr(2'd3, 32'd3);
        reg_wr(2'd1, 32'd1);
        wait_done("R10");
        repeat (5) @(negedge clk);
        check(wn == 0, "R10", wn, 0);
        check(fq_rd == start, "R10", fq_rd, start);

        // R8 start request in the cycle of the final acceptance
        rnd_on = 0;
        start = push_words(6);
        void'(push_words(6));
        wn = 0; expect_n = 6;
        reg_wr(2'd2, 32'h0000_6000);
        reg_wr(2'd3, 32'd24);
        reg_wr(2'd1, 32'd1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1.5;
            if (last_now) begin
                s_write = 1'b1; s_addr = 2'd1; s_writedata = 32'd1;
                @(negedge clk);
                s_write = 1'b0;
                break;
            end
        end
        repeat (12) @(negedge clk);
        check(wn == 6, "R8", wn, 6);
        verify_writes(32'h0000_6000, 6, start);
        reg_rd(2'd0, rd);
        check(rd == 32'd1, "R8", rd, 32'd1);
        fq_wr = fq_rd;

        // random transfers
        rnd_on = 1;
        for (int t = 0; t < 8; t++) begin
            run_xfer($urandom & 32'h00FF_FFFF, $urandom_range(40), 2'($urandom_range(3)));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule